// File: doc/BRIEF.md
# Flit Packetizer for a Router Local Port

This block sits between a processing core and the local port of a mesh router. In the transmit direction it takes a stream of payload words from the core. Each word comes with a last marker, and the first word of a message also carries a destination coordinate and a small tag. The block sends one header flit followed by one flit per payload word. Two framing bits above the data field mark the start and the end of the packet.

In the receive direction the block accepts flits from the router's local port and discards the header. It delivers the payload words to the core with a first-word flag, a last-word flag and the tag that the header carried. It pulses an error output when the framing is broken, and it picks up again at the next header.

Every flit is `DATA_W+2` bits wide:
- bit `DATA_W+1` is the begin bit;
- bit `DATA_W` is the end bit;
- bits `DATA_W-1:0` hold the data.

The header's data field carries:
- destination x in bits `X_W-1:0`;
- destination y in the next `Y_W` bits;
- the tag in the next `TAG_W` bits;
- zeros in the remaining bits.

Routers use only the coordinate bits. All four channels use a valid/acknowledge handshake, and a transfer happens on a clock edge where both signals are high.

Top module: `flit_adapter`

## Requirements
- R1: The first flit of each packet is a header with begin=1 and end=0. Its data field holds x in bits [X_W-1:0], y in [X_W+Y_W-1:X_W] and the tag in [X_W+Y_W+TAG_W-1:X_W+Y_W], with all higher bits zero.
- R2: One payload flit per accepted word follows the header, in order. Each payload flit has begin=0, its data field equal to the word, and end equal to that word's last marker.
- R3: No transmitted flit has both begin and end set.
- R4: The coordinate and tag are taken from the first word of a message only. Their values while later words of the same message are presented have no effect on any flit.
- R5: `tx_ack` is never high for the cycle in which the header is loaded. The first word is acknowledged no earlier than the edge on which the header leaves.
- R6: While `lo_valid` is high and `lo_ack` is low, `lo_valid` stays high and `lo_flit` stays unchanged.
- R7: When the router acknowledges every cycle and the core presents words without pause, `lo_valid` stays high on every cycle from the header's transfer to the trailer's transfer.
- R8: On receive, the header is not delivered. Each later payload flit produces one output word with `rx_last` equal to its end bit, `rx_first` high only on the first word after a header, and `rx_tag` equal to that header's tag field.
- R9: `rx_err` is high for exactly one cycle, the cycle after an accepted flit that breaks framing, in two cases. In the first, a begin flit arrives inside a packet; that flit then opens a new packet. In the second, a payload flit arrives outside any packet; that flit is dropped and produces no output word.
- R10: While `rx_valid` is high and `rx_ack` is low, `rx_valid` and all received-word outputs hold their values.
- R11: During reset `lo_valid`, `rx_valid`, `rx_err` and `tx_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Core offers a payload word |
| tx_ack | output | 1 | Payload word taken this edge |
| tx_dst_x | input | X_W | Destination x, sampled with the first word |
| tx_dst_y | input | Y_W | Destination y, sampled with the first word |
| tx_tag | input | TAG_W | Tag placed in the header's reserved bits |
| tx_data | input | DATA_W | Payload word |
| tx_last | input | 1 | Marks the final word of a message |
| lo_valid | output | 1 | Flit toward the router is valid |
| lo_ack | input | 1 | Router takes the flit |
| lo_flit | output | DATA_W+2 | Flit toward the router |
| ri_valid | input | 1 | Flit from the router is valid |
| ri_ack | output | 1 | Flit from the router taken this edge |
| ri_flit | input | DATA_W+2 | Flit from the router |
| rx_valid | output | 1 | Received word is valid |
| rx_ack | input | 1 | Core takes the received word |
| rx_data | output | DATA_W | Received payload word |
| rx_last | output | 1 | Final word of the packet |
| rx_first | output | 1 | First word of the packet |
| rx_tag | output | TAG_W | Tag carried by the packet's header |
| rx_err | output | 1 | One-cycle framing error pulse |

## Verification
Timing of the two directions:
- **Transmit:** a flit becomes visible on `lo_flit` one edge after the core's word is taken, or one edge after `tx_valid` rises for a header.
- **Receive:** a received word appears on the core side one edge after its flit is accepted.
- **Error pulse:** `rx_err` appears exactly one cycle after the offending flit is accepted.

The bench samples every output at the falling edge and treats a transfer as happening on the following rising edge. Its reference model enqueues expected flits and words when a transfer is seen, and compares them only on the output's own handshake, so back-pressure does not affect the check.

For the error pulse, the model keeps the expectation computed in one cycle and compares it with `rx_err` in the next cycle.

// File: rtl/flit_adapter.sv
module flit_adapter #(
  parameter int DATA_W = 32,
  parameter int X_W    = 4,
  parameter int Y_W    = 4,
  parameter int TAG_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_valid,
  output logic                tx_ack,
  input  logic [X_W-1:0]      tx_dst_x,
  input  logic [Y_W-1:0]      tx_dst_y,
  input  logic [TAG_W-1:0]    tx_tag,
  input  logic [DATA_W-1:0]   tx_data,
  input  logic                tx_last,
  output logic                lo_valid,
  input  logic                lo_ack,
  output logic [DATA_W+1:0]   lo_flit,
  input  logic                ri_valid,
  output logic                ri_ack,
  input  logic [DATA_W+1:0]   ri_flit,
  output logic                rx_valid,
  input  logic                rx_ack,
  output logic [DATA_W-1:0]   rx_data,
  output logic                rx_last,
  output logic                rx_first,
  output logic [TAG_W-1:0]    rx_tag,
  output logic                rx_err
);
  localparam int FLIT_W = DATA_W + 2;
  localparam int BEG    = DATA_W + 1;
  localparam int FIN    = DATA_W;
  localparam int TAG_LO = X_W + Y_W;

  // transmit side
  logic              tx_in_pkt, out_v;
  logic [FLIT_W-1:0] out_flit;
  logic [DATA_W-1:0] hdr_word;
  logic              can_load, hdr_load, pay_load;

  assign can_load = !out_v || lo_ack;
  assign hdr_load = tx_valid && !tx_in_pkt && can_load;
  assign pay_load = tx_valid && tx_in_pkt && can_load;
  assign tx_ack   = pay_load;
  assign lo_valid = out_v;
  assign lo_flit  = out_flit;

  always_comb begin
    hdr_word                  = '0;
    hdr_word[X_W-1:0]         = tx_dst_x;
    hdr_word[X_W +: Y_W]      = tx_dst_y;
    hdr_word[TAG_LO +: TAG_W] = tx_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_in_pkt <= 1'b0;
      out_v     <= 1'b0;
      out_flit  <= '0;
    end else if (hdr_load) begin
      out_v     <= 1'b1;
      out_flit  <= {1'b1, 1'b0, hdr_word};
      tx_in_pkt <= 1'b1;
    end else if (pay_load) begin
      out_v     <= 1'b1;
      out_flit  <= {1'b0, tx_last, tx_data};
      tx_in_pkt <= !tx_last;
    end else if (lo_ack) begin
      out_v     <= 1'b0;
    end
  end

  // receive side
  logic              rx_in_pkt, first_pend, rv, rl, rf, er;
  logic [DATA_W-1:0] rd;
  logic [TAG_W-1:0]  rt, tag_hold;
  logic              f_beg, f_end, out_free, deliver;

  assign f_beg    = ri_flit[BEG];
  assign f_end    = ri_flit[FIN];
  assign out_free = !rv || rx_ack;
  assign ri_ack   = ri_valid && (f_beg || !rx_in_pkt || out_free);
  assign deliver  = ri_ack && !f_beg && rx_in_pkt;

  assign rx_valid = rv;
  assign rx_data  = rd;
  assign rx_last  = rl;
  assign rx_first = rf;
  assign rx_tag   = rt;
  assign rx_err   = er;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_in_pkt  <= 1'b0;
      first_pend <= 1'b0;
      tag_hold   <= '0;
      er         <= 1'b0;
      rv         <= 1'b0;
      rd         <= '0;
      rl         <= 1'b0;
      rf         <= 1'b0;
      rt         <= '0;
    end else begin
      er <= ri_ack && (f_beg ? rx_in_pkt : !rx_in_pkt);
      if (ri_ack && f_beg) begin
        rx_in_pkt  <= 1'b1;
        first_pend <= 1'b1;
        tag_hold   <= ri_flit[TAG_LO +: TAG_W];
      end else if (deliver) begin
        first_pend <= 1'b0;
        if (f_end) rx_in_pkt <= 1'b0;
      end
      if (deliver) begin
        rv <= 1'b1;
        rd <= ri_flit[DATA_W-1:0];
        rl <= f_end;
        rf <= first_pend;
        rt <= tag_hold;
      end else if (rx_ack) begin
        rv <= 1'b0;
      end
    end
  end

  p_lo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid && !lo_ack |=> lo_valid && $stable(lo_flit));

  p_no_dual_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_valid |-> !(lo_flit[BEG] && lo_flit[FIN]));

  p_ack_loads_payload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> lo_valid && !lo_flit[BEG]);

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ack |=> rx_valid && $stable({rx_data, rx_last, rx_first, rx_tag}));

  p_err_follows_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> $past(ri_valid && ri_ack));
endmodule

// File: tb/flit_adapter_tb.sv
module flit_adapter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, XW = 4, YW = 4, TW = 8;
  localparam int FW = DW + 2;

  logic clk = 0, rst_n = 0;
  logic tx_valid = 0, tx_ack, tx_last = 0;
  logic [XW-1:0] tx_dst_x = 0;
  logic [YW-1:0] tx_dst_y = 0;
  logic [TW-1:0] tx_tag = 0;
  logic [DW-1:0] tx_data = 0;
  logic lo_valid, lo_ack = 0;
  logic [FW-1:0] lo_flit;
  logic ri_valid = 0, ri_ack;
  logic [FW-1:0] ri_flit = 0;
  logic rx_valid, rx_ack = 0, rx_last, rx_first, rx_err;
  logic [DW-1:0] rx_data;
  logic [TW-1:0] rx_tag;

  flit_adapter #(.DATA_W(DW), .X_W(XW), .Y_W(YW), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ack(tx_ack), .tx_dst_x(tx_dst_x), .tx_dst_y(tx_dst_y),
    .tx_tag(tx_tag), .tx_data(tx_data), .tx_last(tx_last),
    .lo_valid(lo_valid), .lo_ack(lo_ack), .lo_flit(lo_flit),
    .ri_valid(ri_valid), .ri_ack(ri_ack), .ri_flit(ri_flit),
    .rx_valid(rx_valid), .rx_ack(rx_ack), .rx_data(rx_data), .rx_last(rx_last),
    .rx_first(rx_first), .rx_tag(rx_tag), .rx_err(rx_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  logic [FW-1:0] exp_tx[$];
  logic [DW+TW+1:0] exp_rx[$];
  logic [FW-1:0] stim[$];
  int cur_idx = -1;
  bit ack_force = 0, burst_chk = 0, in_fl = 0, done = 0;
  bit m_in = 0, m_first = 0, err_pend = 0;
  logic [TW-1:0] m_tag = 0;
  int m_errs = 0, dut_errs = 0;
  bit prev_lo_hold = 0, prev_rx_hold = 0;
  logic [FW-1:0] prev_lo_flit;
  logic [DW+TW+1:0] prev_rx_word;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] hdr_of(int m);
    logic [DW-1:0] h = '0;
    h[XW-1:0] = XW'(m);
    h[XW +: YW] = YW'(m + 3);
    h[XW+YW +: TW] = TW'(m * 7 + 1);
    return h;
  endfunction

  function automatic logic [DW-1:0] word_of(int m, int i);
    return 32'hA000_0000 + 32'(m * 256 + i);
  endfunction

  function automatic logic [FW-1:0] mk(bit b, bit e, logic [DW-1:0] d);
    return {b, e, d};
  endfunction

  // handshake pattern drivers
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      lo_ack = ack_force ? 1'b1 : ((k % 3) != 0);
      rx_ack = ((k % 4) != 1);
    end
  end

  // reference model and comparisons, every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog act=%0d exp=<20000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
      // R6 hold from last cycle
      if (prev_lo_hold)
        chk(lo_valid && lo_flit == prev_lo_flit, "R6", 64'(lo_flit), 64'(prev_lo_flit));
      if (prev_rx_hold)
        chk(rx_valid && {rx_tag, rx_first, rx_last, rx_data} == prev_rx_word, "R10",
            64'({rx_tag, rx_first, rx_last, rx_data}), 64'(prev_rx_word));
      prev_lo_hold = lo_valid && !lo_ack;
      prev_lo_flit = lo_flit;
      prev_rx_hold = rx_valid && !rx_ack;
      prev_rx_word = {rx_tag, rx_first, rx_last, rx_data};
      // R5
      if (tx_ack && cur_idx == 0)
        chk(lo_valid && lo_flit[FW-1], "R5 header out before first ack", 64'(lo_flit), 64'(1));
      // R7
      if (burst_chk && in_fl) chk(lo_valid, "R7 no gap", 64'(lo_valid), 64'(1));
      // transmit compare
      if (lo_valid && lo_ack) begin
        logic [FW-1:0] e;
        if (exp_tx.size() == 0) begin
          chk(0, "R2 unexpected flit", 64'(lo_flit), 64'(0));
        end else begin
          e = exp_tx.pop_front();
          chk(lo_flit == e, e[FW-1] ? "R1 R4 header" : "R2 payload", 64'(lo_flit), 64'(e));
        end
        chk(!(lo_flit[FW-1] && lo_flit[FW-2]), "R3", 64'(lo_flit[FW-1:FW-2]), 64'(0));
        if (burst_chk && lo_flit[FW-1]) in_fl = 1;
        if (lo_flit[FW-2]) in_fl = 0;
      end
      // R9 error timing
      chk(rx_err == err_pend, "R9 err pulse", 64'(rx_err), 64'(err_pend));
      if (rx_err) dut_errs++;
      err_pend = 0;
      if (ri_valid && ri_ack) begin
        if (ri_flit[FW-1]) begin
          if (m_in) begin err_pend = 1; m_errs++; end
          m_in = 1; m_first = 1; m_tag = ri_flit[XW+YW +: TW];
        end else if (!m_in) begin
          err_pend = 1; m_errs++;
        end else begin
          exp_rx.push_back({m_tag, m_first, ri_flit[FW-2], ri_flit[DW-1:0]});
          m_first = 0;
          if (ri_flit[FW-2]) m_in = 0;
        end
      end
      // receive compare
      if (rx_valid && rx_ack) begin
        logic [DW+TW+1:0] e;
        if (exp_rx.size() == 0) begin
          chk(0, "R8 unexpected word", 64'(rx_data), 64'(0));
        end else begin
          e = exp_rx.pop_front();
          chk({rx_tag, rx_first, rx_last, rx_data} == e, "R8 word",
              64'({rx_tag, rx_first, rx_last, rx_data}), 64'(e));
        end
      end
    end
  end

  task automatic send_msg(int m);
    int len = (m == 5) ? 9 : (m % 4) + 1;
    exp_tx.push_back(mk(1'b1, 1'b0, hdr_of(m)));
    for (int i = 0; i < len; i++) exp_tx.push_back(mk(1'b0, i == len - 1, word_of(m, i)));
    for (int i = 0; i < len; i++) begin
      tx_valid = 1;
      tx_data  = word_of(m, i);
      tx_last  = (i == len - 1);
      tx_dst_x = (i == 0) ? XW'(m) : ~XW'(m);
      tx_dst_y = (i == 0) ? YW'(m + 3) : YW'(m + 9);
      tx_tag   = (i == 0) ? TW'(m * 7 + 1) : 8'hEE;
      cur_idx  = i;
      do @(negedge clk); while (!tx_ack);
      @(posedge clk); #1;
    end
    tx_valid = 0;
    cur_idx = -1;
    if (m % 3 == 1) begin repeat (2) @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!lo_valid && !rx_valid && !rx_err && !tx_ack, "R11 reset state",
        64'({lo_valid, rx_valid, rx_err, tx_ack}), 64'(0));
    @(posedge clk); #1;
    rst_n = 1;

    for (int m = 0; m < 8; m++) begin
      if (m == 5) begin
        while (exp_tx.size() != 0) @(negedge clk);
        @(posedge clk); #1;
        ack_force = 1; burst_chk = 1;
      end
      send_msg(m);
      if (m == 5) begin
        while (exp_tx.size() != 0) @(negedge clk);
        @(posedge clk); #1;
        ack_force = 0; burst_chk = 0; in_fl = 0;
      end
    end
    while (exp_tx.size() != 0) @(negedge clk);

    // receive stimulus: flit data fields with tag at bits [15:8]
    stim.push_back(mk(1, 0, 32'h0000_1100));
    stim.push_back(mk(0, 0, 32'hA0));
    stim.push_back(mk(0, 0, 32'hA1));
    stim.push_back(mk(0, 1, 32'hA2));
    stim.push_back(mk(0, 0, 32'hB0));
    stim.push_back(mk(0, 1, 32'hB1));
    stim.push_back(mk(1, 0, 32'h0000_2200));
    stim.push_back(mk(0, 0, 32'hC0));
    stim.push_back(mk(1, 0, 32'h0000_3300));
    stim.push_back(mk(0, 0, 32'hD0));
    stim.push_back(mk(0, 1, 32'hD1));
    stim.push_back(mk(1, 0, 32'h0000_4400));
    stim.push_back(mk(0, 1, 32'hE0));
    @(posedge clk); #1;
    for (int k = 0; k < stim.size(); k++) begin
      ri_valid = 1;
      ri_flit = stim[k];
      do @(negedge clk); while (!ri_ack);
      @(posedge clk); #1;
      if (k % 5 == 2) begin ri_valid = 0; @(posedge clk); #1; end
    end
    ri_valid = 0;
    while (exp_rx.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);

    chk(m_errs == 3, "R9 model error count", 64'(m_errs), 64'(3));
    chk(dut_errs == 3, "R9 pulse count", 64'(dut_errs), 64'(3));
    chk(exp_tx.size() == 0, "R2 all flits sent", 64'(exp_tx.size()), 64'(0));
    chk(exp_rx.size() == 0, "R8 all words delivered", 64'(exp_rx.size()), 64'(0));
    chk(!rx_valid, "R8 nothing extra pending", 64'(rx_valid), 64'(0));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule